// File: doc/BRIEF.md
# Tamper sensor aggregation controller

This block gathers the trip lines of four physical fault sensors (supply voltage, clock frequency, temperature and an anti-probing mesh) and turns them into a single, software-configurable tamper response. Each raw trip line is first brought into the local clock domain by a two-flop synchronizer. A synchronized trip counts only when the enable bit for that sensor is set. Every sensor starts out disabled, so after reset nothing is armed until software writes the enable register.

An enabled trip latches a sticky per-sensor flag and holds a level interrupt toward the processor. Depending on an action register, it also sends a one-cycle system-reset request and/or a one-cycle key-wipe request. Software reads and writes the three registers through a small synchronous write port with a combinational read mux. A flag is acknowledged by writing 1 to its bit. The analog sensors, the interrupt controller and the key store are outside the block and appear only as single-bit lines.

Top module: `tamper_hub`

## Requirements
- R1: While `rst_n` is low and after it is released, the enable, action and flag registers read 0, and `irq`, `reset_req` and `wipe_req` are 0.
- R2: A rise on `sensor_trip[i]` that is set up before a rising clock edge is reflected in the flag register, `irq` and the request pulses at the third rising edge, counting that edge as the first. Earlier edges show no effect.
- R3: Address 0 is the enable register. Bits 0, 1, 2 and 3 arm the voltage, clock, temperature and mesh sensors (sensor index i = bit i). A write stores `reg_wdata[3:0]`, and reads return the stored value zero-extended.
- R4: A trip on a sensor whose enable bit is 0 sets no flag, raises no `irq` and issues no request.
- R5: Address 2 is the flag register. Flag bit i is set while sensor i is enabled and its synchronized trip is high, and it stays set after the trip goes away.
- R6: Writing 1 to a flag bit at address 2 clears it, and writing 0 leaves it unchanged. If a clear and a set of the same bit fall in the same cycle, the set wins.
- R7: `irq` is high exactly while some flag bit is set whose enable bit is also set. It does not fall without a register write.
- R8: Address 1 is the action register. Bit 0 enables the reset request and bit 1 enables the wipe request. Reads return these two bits zero-extended.
- R9: When at least one enabled sensor's synchronized trip rises (a new event) and action bit 0 is set, `reset_req` is high for exactly one cycle. A trip held high produces no further pulse, and simultaneous rises produce one pulse.
- R10: `wipe_req` follows the same one-cycle, once-per-new-event rule, gated by action bit 1 and independent of bit 0.
- R11: Writes to address 3 have no effect, address 3 reads 0, and unused upper data bits of every register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sensor_trip | input | 4 | Raw trip lines, bit i = sensor i (voltage, clock, temperature, mesh) |
| reg_we | input | 1 | Register write strobe, acts at the next rising edge |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq | output | 1 | Level tamper interrupt |
| reset_req | output | 1 | One-cycle system-reset request |
| wipe_req | output | 1 | One-cycle key-wipe request |

## Verification
The bound checker enforces the following on every cycle:
- a flag never rises for a sensor that was disabled;
- flags only fall on a write to the flag register;
- `irq`, once high, stays high until a register write;
- each request pulse appears only when its action bit was set one cycle earlier.

Some behaviours are visible only through the bench's scenarios, where a behavioural model runs beside the design and is compared on every clock:
- the exact three-edge synchronizer latency;
- the single pulse for simultaneous rises versus a second pulse for a later rise;
- the set-beats-clear ordering;
- the ignored spare address.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
    // register selects
    localparam int SEL_ENABLE = 0;
    localparam int SEL_ACTION = 1;
    localparam int SEL_FLAGS  = 2;
    localparam int SEL_SPARE  = 3;

    // action register layout
    localparam int ACT_W        = 2;
    localparam int ACT_RST_BIT  = 0;
    localparam int ACT_WIPE_BIT = 1;

    // sensor indices
    typedef enum int {
        SNS_VOLT = 0,
        SNS_CLK  = 1,
        SNS_TEMP = 2,
        SNS_MESH = 3
    } sensor_e;
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] sync_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign sync_o = raw_i;
        end else begin : g_chain
            typedef struct packed {
                logic [STAGES-1:0][N-1:0] stage;
            } chain_t;

            chain_t c_d, c_q;

            always_comb begin
                c_d = c_q;
                c_d.stage[0] = raw_i;
                for (int s = 1; s < STAGES; s++) begin
                    c_d.stage[s] = c_q.stage[s-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) c_q <= '0;
                else        c_q <= c_d;
            end

            assign sync_o = c_q.stage[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tamper_regs.sv
module tamper_regs
    import tamper_pkg::*;
#(
    parameter int N      = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N-1:0]      set_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N-1:0]      en_o,
    output logic [ACT_W-1:0]  act_o,
    output logic [N-1:0]      flags_o
);
    localparam int PAD_N   = DATA_W - N;
    localparam int PAD_ACT = DATA_W - ACT_W;

    typedef struct packed {
        logic [N-1:0]     en;
        logic [ACT_W-1:0] act;
        logic [N-1:0]     flags;
    } regs_t;

    regs_t          r_d, r_q;
    logic           sel_en, sel_act, sel_flags;
    logic [N-1:0]   clr;
    logic           unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[DATA_W-1:N];

    always_comb begin
        sel_en    = (addr_i == ADDR_W'(SEL_ENABLE));
        sel_act   = (addr_i == ADDR_W'(SEL_ACTION));
        sel_flags = (addr_i == ADDR_W'(SEL_FLAGS));

        r_d = r_q;
        if (we_i && sel_en)  r_d.en  = wdata_i[N-1:0];
        if (we_i && sel_act) r_d.act = wdata_i[ACT_W-1:0];

        // acknowledge first, then new sets so a set wins
        clr = (we_i && sel_flags) ? wdata_i[N-1:0] : '0;
        r_d.flags = (r_q.flags & ~clr) | set_i;

        rdata_o = '0;
        if (sel_en)    rdata_o = {{PAD_N{1'b0}}, r_q.en};
        if (sel_act)   rdata_o = {{PAD_ACT{1'b0}}, r_q.act};
        if (sel_flags) rdata_o = {{PAD_N{1'b0}}, r_q.flags};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign en_o    = r_q.en;
    assign act_o   = r_q.act;
    assign flags_o = r_q.flags;
endmodule

// File: rtl/tamper_resp.sv
module tamper_resp
    import tamper_pkg::*;
#(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     hit_i,
    input  logic [ACT_W-1:0] act_i,
    input  logic [N-1:0]     flags_i,
    input  logic [N-1:0]     en_i,
    output logic             irq_o,
    output logic             reset_req_o,
    output logic             wipe_req_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic         rst;
        logic         wipe;
    } resp_t;

    resp_t        s_d, s_q;
    logic [N-1:0] rise;
    logic         new_evt;

    always_comb begin
        rise    = hit_i & ~s_q.prev;
        new_evt = |rise;

        s_d      = s_q;
        s_d.prev = hit_i;
        s_d.rst  = new_evt && act_i[ACT_RST_BIT];
        s_d.wipe = new_evt && act_i[ACT_WIPE_BIT];

        irq_o = |(flags_i & en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reset_req_o = s_q.rst;
    assign wipe_req_o  = s_q.wipe;
endmodule

// File: rtl/tamper_hub.sv
module tamper_hub
    import tamper_pkg::*;
#(
    parameter int N_SENS      = 4,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SENS-1:0] sensor_trip,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              reset_req,
    output logic              wipe_req
);
    logic [N_SENS-1:0] sync_w;
    logic [N_SENS-1:0] hit_w;
    logic [N_SENS-1:0] en_w;
    logic [N_SENS-1:0] flags_w;
    logic [ACT_W-1:0]  act_w;

    tamper_sync #(.N(N_SENS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (sensor_trip),
        .sync_o (sync_w)
    );

    assign hit_w = sync_w & en_w;

    tamper_regs #(.N(N_SENS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .set_i   (hit_w),
        .rdata_o (reg_rdata),
        .en_o    (en_w),
        .act_o   (act_w),
        .flags_o (flags_w)
    );

    tamper_resp #(.N(N_SENS)) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit_w),
        .act_i       (act_w),
        .flags_i     (flags_w),
        .en_i        (en_w),
        .irq_o       (irq),
        .reset_req_o (reset_req),
        .wipe_req_o  (wipe_req)
    );
endmodule

// File: rtl/tamper_hub_chk.sv
module tamper_hub_chk
    import tamper_pkg::*;
#(
    parameter int N_SENS = 4,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              irq,
    input logic              reset_req,
    input logic              wipe_req,
    input logic [N_SENS-1:0] en,
    input logic [ACT_W-1:0]  act,
    input logic [N_SENS-1:0] flags
);
    // R4: a flag can only appear for a sensor that was enabled
    p_no_disabled_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(en)) == '0));

    // R5: flags only fall on a write to the flag register
    p_flags_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == ADDR_W'(SEL_FLAGS)) |=> ((flags & $past(flags)) == $past(flags)));

    // R7: interrupt holds until some register write
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_we) |=> irq);

    // R9: reset pulse only when its action bit was set
    p_reset_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(act[ACT_RST_BIT]));

    // R10: wipe pulse only when its action bit was set
    p_wipe_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_req |-> $past(act[ACT_WIPE_BIT]));
endmodule

bind tamper_hub tamper_hub_chk #(.N_SENS(N_SENS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .irq       (irq),
    .reset_req (reset_req),
    .wipe_req  (wipe_req),
    .en        (en_w),
    .act       (act_w),
    .flags     (flags_w)
);

// File: tb/tamper_hub_test.sv
module tamper_hub_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sensor_trip = '0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, reset_req, wipe_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    tamper_hub uut (
        .clk(clk), .rst_n(rst_n), .sensor_trip(sensor_trip),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .reset_req(reset_req), .wipe_req(wipe_req)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit [3:0] m_en, m_flags, m_prev, m_old, m_hit, m_clr;
    bit [1:0] m_act;
    bit       m_rst, m_wipe;
    bit [3:0] pipe[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_flags = 0; m_prev = 0; m_act = 0; m_rst = 0; m_wipe = 0;
            pipe.delete();
        end else begin
            m_old  = (pipe.size() == 2) ? pipe[0] : 4'b0;
            m_hit  = m_old & m_en;
            m_rst  = ((m_hit & ~m_prev) != 0) && m_act[0];
            m_wipe = ((m_hit & ~m_prev) != 0) && m_act[1];
            m_clr  = (reg_we && reg_addr == 2) ? reg_wdata[3:0] : 4'b0;
            m_flags = (m_flags & ~m_clr) | m_hit;
            if (reg_we && reg_addr == 0) m_en  = reg_wdata[3:0];
            if (reg_we && reg_addr == 1) m_act = reg_wdata[1:0];
            m_prev = m_hit;
            pipe.push_back(sensor_trip);
            if (pipe.size() > 2) void'(pipe.pop_front());
        end
    end

    function automatic logic [7:0] exp_rd(logic [1:0] a);
        case (a)
            2'd0:    return {4'b0, m_en};
            2'd1:    return {6'b0, m_act};
            2'd2:    return {4'b0, m_flags};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(logic [1:0] a);
        case (a)
            2'd0:    return "R3 enable read";
            2'd1:    return "R8 action read";
            2'd2:    return "R5 flag read";
            default: return "R11 spare read";
        endcase
    endfunction

    always @(negedge clk) begin
        chk("R7 irq vs model", {7'b0, irq}, {7'b0, ((m_flags & m_en) != 0)});
        chk("R9 reset_req vs model", {7'b0, reset_req}, {7'b0, m_rst});
        chk("R10 wipe_req vs model", {7'b0, wipe_req}, {7'b0, m_wipe});
        chk(rd_tag(reg_addr), reg_rdata, exp_rd(reg_addr));
    end

    task automatic cyc(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string tag);
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        cyc(3);
        @(negedge clk);
        chk("R1 irq in reset", {7'b0, irq}, 8'h0);
        chk("R1 reset_req in reset", {7'b0, reset_req}, 8'h0);
        chk("R1 wipe_req in reset", {7'b0, wipe_req}, 8'h0);
        rst_n = 1'b1;
        cyc();
        rd_chk(2'd0, 8'h00, "R1 enable after reset");
        rd_chk(2'd1, 8'h00, "R1 action after reset");
        rd_chk(2'd2, 8'h00, "R1 flags after reset");

        // R4: trips while nothing is enabled
        sensor_trip = 4'b1111;
        cyc(5);
        rd_chk(2'd2, 8'h00, "R4 flags with sensors disabled");
        chk("R4 irq with sensors disabled", {7'b0, irq}, 8'h0);
        sensor_trip = 4'b0000;
        cyc(3);

        // R3 / R8 / R11: register fields
        wr(2'd0, 8'hF5);
        rd_chk(2'd0, 8'h05, "R3 enable stores low nibble");
        wr(2'd0, 8'h01);
        wr(2'd1, 8'hFF);
        rd_chk(2'd1, 8'h03, "R11 action upper bits read zero");
        wr(2'd1, 8'h03);
        rd_chk(2'd1, 8'h03, "R8 action readback");

        // R2: latency of the synchronizer, R9/R10 pulses
        reg_addr = 2'd2;
        sensor_trip[0] = 1'b1;
        cyc(); @(negedge clk);
        chk("R2 no flag after edge 1", reg_rdata, 8'h00);
        cyc(); @(negedge clk);
        chk("R2 no flag after edge 2", reg_rdata, 8'h00);
        chk("R2 no reset pulse after edge 2", {7'b0, reset_req}, 8'h0);
        cyc(); @(negedge clk);
        chk("R2 flag after edge 3", reg_rdata, 8'h01);
        chk("R9 reset pulse on new event", {7'b0, reset_req}, 8'h1);
        chk("R10 wipe pulse on new event", {7'b0, wipe_req}, 8'h1);
        chk("R7 irq with enabled flag", {7'b0, irq}, 8'h1);
        cyc(); @(negedge clk);
        chk("R9 reset pulse lasts one cycle", {7'b0, reset_req}, 8'h0);
        chk("R10 wipe pulse lasts one cycle", {7'b0, wipe_req}, 8'h0);
        cyc(3); @(negedge clk);
        chk("R9 no repeat while trip held", {7'b0, reset_req}, 8'h0);

        // R5: sticky after trip drops
        sensor_trip[0] = 1'b0;
        cyc(4);
        rd_chk(2'd2, 8'h01, "R5 flag sticky after trip drops");
        chk("R7 irq held by sticky flag", {7'b0, irq}, 8'h1);

        // R6: write-one-to-clear
        wr(2'd2, 8'h00);
        rd_chk(2'd2, 8'h01, "R6 writing 0 keeps flag");
        wr(2'd2, 8'h01);
        rd_chk(2'd2, 8'h00, "R6 writing 1 clears flag");
        chk("R7 irq low after clear", {7'b0, irq}, 8'h0);

        // R6: set wins over clear
        wr(2'd0, 8'h03);
        sensor_trip[1] = 1'b1;
        cyc(3);
        rd_chk(2'd2, 8'h02, "R6 clock flag set");
        wr(2'd2, 8'h02);
        rd_chk(2'd2, 8'h02, "R6 set wins over clear");

        // R7: disabling masks the interrupt, flag remains
        wr(2'd0, 8'h01);
        @(negedge clk);
        chk("R7 irq masked by enable", {7'b0, irq}, 8'h0);
        rd_chk(2'd2, 8'h02, "R7 flag kept while masked");
        sensor_trip[1] = 1'b0;
        cyc(3);
        wr(2'd2, 8'h0F);

        // R9 / R10: simultaneous rises give one pulse, later rise another
        wr(2'd0, 8'h0F);
        wr(2'd1, 8'h01);
        sensor_trip = 4'b1100;
        cyc(3); @(negedge clk);
        chk("R9 one pulse for simultaneous rises", {7'b0, reset_req}, 8'h1);
        chk("R10 wipe gated off by action bit", {7'b0, wipe_req}, 8'h0);
        cyc(); @(negedge clk);
        chk("R9 single pulse for simultaneous rises", {7'b0, reset_req}, 8'h0);
        sensor_trip[0] = 1'b1;
        cyc(3); @(negedge clk);
        chk("R9 new pulse for later rise", {7'b0, reset_req}, 8'h1);

        // R8: no action bits, only flag and irq
        wr(2'd1, 8'h00);
        sensor_trip = 4'b0000;
        cyc(3);
        wr(2'd2, 8'h0F);
        cyc();
        sensor_trip[3] = 1'b1;
        cyc(3); @(negedge clk);
        chk("R8 no reset pulse with action 0", {7'b0, reset_req}, 8'h0);
        chk("R8 no wipe pulse with action 0", {7'b0, wipe_req}, 8'h0);
        chk("R8 irq still raised", {7'b0, irq}, 8'h1);
        sensor_trip = 4'b0000;

        // R11: spare address
        wr(2'd3, 8'hFF);
        rd_chk(2'd3, 8'h00, "R11 spare reads zero");
        rd_chk(2'd0, 8'h0F, "R11 spare write left enable alone");
        rd_chk(2'd1, 8'h00, "R11 spare write left action alone");
        cyc(4);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule